// File: doc/BRIEF.md
# Self-Masked Interface Enable Register

This block holds the enable switches for the major interface functions of a larger device. There are two 32-bit control words. Each word drives sixteen enable lines, so together they give 32 enable outputs. Software writes a word in a self-masking format. The lower half of the write data holds new switch values. The upper half says which of those values are to be taken.

A control bit changes only where its mask bit in the same write is 1. Every other bit keeps its state. Software can therefore turn chosen interfaces on or off with a single write. It does not need to read back the settings of the other interfaces first.

The mask is not stored. A read returns the sixteen switch values in the low half of the word and zeros in the high half. A simple address input selects the word for a read or a write.

Top module: `ctrl_mask_regs`

## Requirements
- R1: After synchronous reset, every enable output is 0 and both words read back as 0.
- R2: On a write, control bit i of the addressed word takes write-data bit i wherever write-data bit i+16 (its mask bit) is 1.
- R3: On a write, control bit i of the addressed word keeps its previous value wherever mask bit i+16 is 0.
- R4: A write whose mask half (bits 31 to 16) is all zero leaves the addressed word unchanged.
- R5: A read returns the current control bits of the addressed word on rd_data[15:0], and 0 on rd_data[31:16]. The read data is combinational from the address.
- R6: A write to one word leaves the other word unchanged.
- R7: The written value appears on the enable outputs on the clock edge that accepts the write, and not before it.
- R8: Address 0 selects word 0, which drives enables[15:0]. Address 1 selects word 1, which drives enables[31:16].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the selected word |
| addr | input | 1 | Word select (0 or 1) |
| wr_data | input | 32 | Mask in [31:16], new control values in [15:0] |
| rd_data | output | 32 | Control values of the selected word in [15:0], zero in [31:16] |
| enables | output | 32 | Word 1 in [31:16], word 0 in [15:0] |

## Verification
On every cycle, the assertions check four things:
- only one word receives a write strobe at a time;
- a word that is not written holds its value;
- masked bits take the written data and unmasked bits hold;
- the read data's upper half is zero.

Only the bench scenarios can show the rest. These are the reset state, the mapping of each address to its half of the enable outputs, and the one-edge timing of a write. A sweep of mask and data patterns across both words, compared against an arithmetic model, also confirms that the values that build up over many writes are right.

// File: rtl/cmr_pkg.sv
package cmr_pkg;
    localparam int CTRL_W    = 16;
    localparam int WORD_W    = 2 * CTRL_W;
    localparam int NUM_WORDS = 2;

    typedef logic [CTRL_W-1:0] ctrl_t;

    typedef struct packed {
        ctrl_t mask;
        ctrl_t value;
    } wr_word_t;

    function automatic ctrl_t apply_mask(input ctrl_t cur, input wr_word_t w);
        return (cur & ~w.mask) | (w.value & w.mask);
    endfunction
endpackage

// File: rtl/cmr_wr_decode.sv
module cmr_wr_decode #(
    parameter int NUM_WORDS = 2,
    parameter int ADDR_W    = 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    addr,
    output logic [NUM_WORDS-1:0] we
);
    always_comb begin
        we = '0;
        for (int i = 0; i < NUM_WORDS; i++) begin
            if (wr_en && addr == ADDR_W'(i)) we[i] = 1'b1;
        end
    end

    // R6
    one_strobe_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(we));
endmodule

// File: rtl/cmr_word.sv
module cmr_word
    import cmr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     we,
    input  wr_word_t wdata,
    output ctrl_t    ctrl
);
    always_ff @(posedge clk) begin
        if (rst)     ctrl <= '0;
        else if (we) ctrl <= apply_mask(ctrl, wdata);
    end

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(ctrl));
    // R2
    masked_take_chk: assert property (@(posedge clk) disable iff (rst)
        we |=> ((ctrl & $past(wdata.mask)) == ($past(wdata.value) & $past(wdata.mask))));
    // R3
    unmasked_hold_chk: assert property (@(posedge clk) disable iff (rst)
        we |=> (((ctrl ^ $past(ctrl)) & ~$past(wdata.mask)) == '0));
endmodule

// File: rtl/cmr_read_mux.sv
module cmr_read_mux
    import cmr_pkg::*;
#(
    parameter int NUM_WORDS = 2,
    parameter int ADDR_W    = 1
) (
    input  logic [ADDR_W-1:0]           addr,
    input  ctrl_t [NUM_WORDS-1:0]       words,
    output logic [WORD_W-1:0]           rd_data
);
    ctrl_t sel;

    always_comb begin
        sel = '0;
        for (int i = 0; i < NUM_WORDS; i++) begin
            if (addr == ADDR_W'(i)) sel = words[i];
        end
        rd_data = {{(WORD_W-CTRL_W){1'b0}}, sel};
    end

    // R5
    always_comb begin
        upper_zero_chk: assert (rd_data[WORD_W-1:CTRL_W] == '0);
    end
endmodule

// File: rtl/ctrl_mask_regs.sv
module ctrl_mask_regs
    import cmr_pkg::*;
#(
    parameter int N_WORDS = NUM_WORDS,
    localparam int ADDR_W = (N_WORDS > 1) ? $clog2(N_WORDS) : 1,
    localparam int EN_W   = N_WORDS * CTRL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] rd_data,
    output logic [EN_W-1:0]   enables
);
    logic [N_WORDS-1:0]  we;
    ctrl_t [N_WORDS-1:0] words;
    wr_word_t            wword;

    assign wword = wr_word_t'(wr_data);

    cmr_wr_decode #(.NUM_WORDS(N_WORDS), .ADDR_W(ADDR_W)) u_dec (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .we(we)
    );

    for (genvar g = 0; g < N_WORDS; g++) begin : g_word
        cmr_word u_word (
            .clk(clk), .rst(rst), .we(we[g]), .wdata(wword), .ctrl(words[g])
        );
        assign enables[g*CTRL_W +: CTRL_W] = words[g];
    end

    cmr_read_mux #(.NUM_WORDS(N_WORDS), .ADDR_W(ADDR_W)) u_rd (
        .addr(addr), .words(words), .rd_data(rd_data)
    );
endmodule

// File: tb/ctrl_mask_regs_bench.sv
module ctrl_mask_regs_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        addr = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [31:0] enables;

    int total = 0;
    int bad = 0;
    logic [15:0] model [2];

    ctrl_mask_regs u_ctrl_mask_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .enables(enables)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic a, input logic [31:0] d, input string req);
        logic [15:0] m;
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        #1 check("R7", enables, {model[1], model[0]});
        m = d[31:16];
        model[a] = (model[a] & ~m) | (d[15:0] & m);
        @(negedge clk);
        wr_en = 1'b0;
        check(req, enables, {model[1], model[0]});
    endtask

    task automatic do_read(input logic a, input string req);
        @(negedge clk);
        addr = a;
        #1 check(req, rd_data, {16'h0, model[a]});
    endtask

    initial begin
        model[0] = '0; model[1] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        check("R1", enables, 32'h0);
        do_read(1'b0, "R1");
        do_read(1'b1, "R1");
        // R8 address mapping
        do_write(1'b0, 32'hFFFF_00FF, "R8");
        check("R8", enables[31:16], 32'h0);
        do_write(1'b1, 32'hFFFF_A500, "R8");
        check("R8", enables, 32'hA500_00FF);
        // R4 zero mask
        do_write(1'b0, 32'h0000_FF00, "R4");
        check("R4", enables, 32'hA500_00FF);
        do_write(1'b1, 32'h0000_5AFF, "R4");
        check("R4", enables, 32'hA500_00FF);
        // R3 partial mask
        do_write(1'b0, 32'h0F00_FFFF, "R3");
        check("R3", enables[15:0], 32'h0FFF);
        // R2 / R6 sweep
        for (int m = 0; m < 16; m++) begin
            for (int d = 0; d < 16; d++) begin
                logic w;
                w = (m + d) % 2 == 1;
                do_write(w, {{4{4'(m)}}, {4{4'(d)}}}, "R2");
                do_read(w, "R5");
                do_read(!w, "R6");
            end
        end
        // R1 reset again
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        model[0] = '0; model[1] = '0;
        check("R1", enables, 32'h0);
        do_read(1'b1, "R1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule